// File: doc/BRIEF.md
# Successive-Approximation Search Controller

This block is the digital half of a successive-approximation converter. A start pulse makes it run a binary search over an N-bit code. It resolves one bit per clock, from the most significant bit down to the least. On each cycle of the search it drives a trial code to an external DAC. On the next clock edge it samples a single comparator line, which reports whether the analog input is at or above the level of that trial code.

The first trial puts a 1 in the top bit only, which is mid-scale. After every comparison the bit under test is kept or cleared. The next lower bit is then set on top of the bits already decided, so each trial lies halfway between the bounds that remain. The search always settles on the largest code whose level does not exceed the input, so the converter rounds down and has a mid-rise transfer. When the last bit is decided, the final code appears on the result output together with a one-cycle done strobe. The result then stays unchanged until the following conversion completes.

One conversion occupies the cycle that accepts the start pulse plus N search cycles. A new start is accepted in the done cycle, so back-to-back conversions take N+1 clocks each. The clock must therefore run at least N+1 times faster than the wanted sample rate. The width N may be set from 4 to 16.

Top module: `sar_search_ctrl`

## Requirements
- R1: A start pulse sampled while the block is idle makes busy high in the next cycle, with a trial code that has only its top bit set (bit N-1 = 1, all other bits 0).
- R2: During the search, the trial code for bit k holds the bits already decided above k, a 1 at bit k, and zeros below k.
- R3: The comparator input is 1 when the analog input is at or above the level of the trial code. On the clock edge that resolves bit k, a 1 keeps bit k at 1 and a 0 clears it.
- R4: The final code equals floor(vin * 2^N / vref), the largest code whose level does not exceed the input. For example, with 4 bits, an input of 60 and full scale 100 give 1001.
- R5: done is high for exactly one cycle. It rises on the N-th clock edge after the edge that accepted start, and busy is low in that cycle.
- R6: The result output changes only in the cycle where done is high and otherwise holds the last completed code.
- R7: A start pulse while busy is ignored: the running search keeps its timing and its result.
- R8: After reset, busy and done are low and both the result and the trial code are zero.
- R9: A start pulse applied in the done cycle is accepted, so conversions can follow one another every N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, acted on only when idle |
| cmp_above_i | input | 1 | Comparator: 1 when the input is at or above the trial DAC level |
| trial_code_o | output | N | Code driven to the DAC |
| busy_o | output | 1 | High while the search is running |
| done_o | output | 1 | One-cycle strobe when the result is final |
| result_o | output | N | Last completed conversion code |

## Verification
The search is exercised with inputs at zero, just below full scale, and on exact code boundaries such as 100/256 and 128/256. The boundary cases show whether a tie at the comparator keeps the bit and whether the result rounds down. A spread of pseudo-random inputs against a 4096 full scale checks the trial code bit by bit at every step, so a wrong step order or a wrong keep/clear decision shows up as a mismatch at a specific step. Extra start pulses in the middle of a search reveal whether a busy search can be restarted. Starts issued in the done cycle confirm the N+1 cycle back-to-back rate.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } sar_phase_e;
endpackage

// File: rtl/sar_step_fsm.sv
module sar_step_fsm
  import sar_pkg::*;
#(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            busy_o,
  output logic            load_o,
  output logic            step_o,
  output logic            last_o,
  output logic [IDXW-1:0] ptr_o,
  output logic            done_o
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(N - 1);

  sar_phase_e      phase_q, phase_d;
  logic [IDXW-1:0] ptr_q, ptr_d;
  logic            done_q;

  assign busy_o = (phase_q == PH_CONV);
  assign load_o = (phase_q == PH_IDLE) && start_i;
  assign step_o = busy_o;
  assign last_o = busy_o && (ptr_q == '0);
  assign ptr_o  = ptr_q;
  assign done_o = done_q;

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_CONV;
          ptr_d   = TOP_IDX;
        end
      end
      PH_CONV: begin
        if (ptr_q == '0) phase_d = PH_IDLE;
        else             ptr_d   = ptr_q - IDXW'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (load_o || step_o) ptr_q <= ptr_d;
      done_q  <= last_o;
    end
  end

  // R5: the completion strobe never lasts two cycles
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: a start request during a search does not disturb the bit pointer
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && (ptr_o != '0)) |=> (busy_o && (ptr_o == $past(ptr_o) - IDXW'(1))));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [IDXW-1:0] ptr_i,
  input  logic            cmp_i,
  output logic [N-1:0]    work_o,
  output logic [N-1:0]    work_next_o
);
  localparam logic [N-1:0] MID_CODE = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] work_q, work_d;

  always_comb begin
    work_d = work_q;
    if (load_i) begin
      work_d = MID_CODE;
    end else if (step_i) begin
      work_d[ptr_i] = cmp_i;
      if (ptr_i != '0) work_d[ptr_i - IDXW'(1)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                work_q <= '0;
    else if (load_i || step_i) work_q <= work_d;
  end

  assign work_o      = work_q;
  assign work_next_o = work_d;

  // R3: the resolved bit follows the comparator sampled on that edge
  p_keep_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (work_q[$past(ptr_i)] == $past(cmp_i)));

  // R2: the next lower bit becomes the new trial bit
  p_next_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (ptr_i != '0)) |=> work_q[$past(ptr_i) - IDXW'(1)]);
endmodule

// File: rtl/sar_result_latch.sv
module sar_result_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_i,
  input  logic [N-1:0] code_i,
  input  logic         done_i,
  output logic [N-1:0] result_o
);
  logic [N-1:0] result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (capture_i) result_q <= code_i;
  end

  assign result_o = result_q;

  // R6: the held result moves only together with the done strobe
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_i);
endmodule

// File: rtl/sar_search_ctrl.sv
module sar_search_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_above_i,
  output logic [N-1:0] trial_code_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] result_o
);
  localparam int IDXW = $clog2(N);
  localparam logic [N-1:0] MID_CODE = {1'b1, {(N-1){1'b0}}};

  logic            load_w, step_w, last_w;
  logic [IDXW-1:0] ptr_w;
  logic [N-1:0]    work_w, work_next_w;

  sar_step_fsm #(.N(N), .IDXW(IDXW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .load_o  (load_w),
    .step_o  (step_w),
    .last_o  (last_w),
    .ptr_o   (ptr_w),
    .done_o  (done_o)
  );

  sar_trial_reg #(.N(N), .IDXW(IDXW)) u_trial (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_w),
    .step_i      (step_w),
    .ptr_i       (ptr_w),
    .cmp_i       (cmp_above_i),
    .work_o      (work_w),
    .work_next_o (work_next_w)
  );

  sar_result_latch #(.N(N)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (last_w),
    .code_i    (work_next_w),
    .done_i    (done_o),
    .result_o  (result_o)
  );

  assign trial_code_o = work_w;

  // R1: an accepted start opens the search at mid-scale
  p_first_trial_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && (trial_code_o == MID_CODE)));

  // R5: busy is low whenever done is reported
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_sar_search_ctrl.sv
`timescale 1ns/1ps
module tb_sar_search_ctrl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp;
  logic [N-1:0] trial, result;
  logic         busy, done;

  int vin  = 0;
  int vref = 100;

  always #4 clk = ~clk;

  // behavioural DAC plus comparator: input at or above trial level
  assign cmp = (longint'(vin) * (longint'(1) << N)) >= (longint'(trial) * longint'(vref));

  sar_search_ctrl #(.N(N)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .cmp_above_i  (cmp),
    .trial_code_o (trial),
    .busy_o       (busy),
    .done_o       (done),
    .result_o     (result)
  );

  typedef struct { int code; int t0; } exp_t;
  exp_t exp_q[$];

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  int  last_code = 0;
  bit  done_prev = 1'b0;
  bit  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: pops expected results when done is seen
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && done_prev) check(1'b0, "R5 done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(result == N'(e.code), "R4 final code", int'(result), e.code);
          check(cyc - e.t0 == N, "R5 latency", cyc - e.t0, N);
          check(!busy, "R5 busy low with done", int'(busy), 0);
          last_code = e.code;
        end
      end
      done_prev = done;
    end
  end

  // driver: one conversion with step-by-step trial checks
  task automatic convert(input int v, input int r, input bit poke, input bit tight);
    int code;
    if (!tight) @(negedge clk);
    vin = v; vref = r;
    code = int'((longint'(v) * (longint'(1) << N)) / longint'(r));
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    exp_q.push_back('{code: code, t0: cyc});
    check(busy, "R1 busy after start", int'(busy), 1);
    check(result == N'(last_code), "R6 result held during search", int'(result), last_code);
    for (int k = N - 1; k >= 0; k--) begin
      int et;
      if (k != N - 1) @(negedge clk);
      start = (poke && k == N - 3) ? 1'b1 : 1'b0;
      et = ((code >> (k + 1)) << (k + 1)) | (1 << k);
      if (k == N - 1) check(trial == N'(et), "R1 first trial mid-scale", int'(trial), et);
      else            check(trial == N'(et), "R2/R3 trial code step", int'(trial), et);
    end
    start = 1'b0;
    @(negedge clk);
    #1;
    check(exp_q.size() == 0, "R7/R5 conversion completed on time", exp_q.size(), 0);
  endtask

  initial begin
    int lcg;
    lcg = 12345;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R8 busy after reset", int'(busy), 0);
    check(!done, "R8 done after reset", int'(done), 0);
    check(result == '0, "R8 result after reset", int'(result), 0);
    check(trial == '0, "R8 trial after reset", int'(trial), 0);

    convert(60, 100, 1'b0, 1'b0);
    convert(0, 100, 1'b0, 1'b0);
    convert(99, 100, 1'b1, 1'b0);   // R7 start poked mid-search
    convert(999, 1000, 1'b0, 1'b1); // R9 start in done cycle
    convert(100, 256, 1'b0, 1'b1);  // R4 exact boundary
    convert(128, 256, 1'b1, 1'b0);
    convert(127, 256, 1'b0, 1'b0);
    convert(1, 256, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      convert((lcg >> 8) % 4096, 4096, (i % 5) == 2, (i % 3) == 1);
    end
    // R6: result holds while idle
    repeat (4) @(negedge clk);
    check(result == N'(last_code), "R6 result held while idle", int'(result), last_code);
    check(!busy && !done, "R7 block idle at end", int'(busy), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule